// File: doc/BRIEF.md
# Reset-Time Bus Mode Strap Latch

This block samples a set of bus configuration straps when the local reset is released. It decodes them into a bus mode (conventional PCI or PCI-X) and a clock frequency range class. The captured result feeds clock generation and other clock-dependent logic. It is held through any later local reset, so that those clocks stay stable while the bus interface is being reset.

A small two-state machine controls the hold:

- **ST_OPEN** is the state after the reopen condition. The outputs sit at their defaults and `cfg_valid` is low.
- **CAPTURE** is the transition from ST_OPEN to ST_HELD. It is taken on the clock where the synchronized local reset is first seen high.
- **ST_HELD** keeps the captured value.
- **REOPEN** is the transition from ST_HELD back to ST_OPEN. It is an asynchronous return, taken only while the power-up reset and the local reset are low together.

Every reset and strap input passes through a synchronizer of `SYNC_STAGES` flops before it is used.

The block also reports two conditions seen at capture. One is whether the PLL reset had already been released. The other is whether the three idle-high straps were all high.

Top module: `bus_strap_latch`

## Requirements
- R1: The straps are captured exactly `SYNC_STAGES`+1 rising clock edges after the local reset input goes high while in ST_OPEN. `cfg_valid` is still low after `SYNC_STAGES` edges.
- R2: In ST_HELD, a local reset pulse with the power-up reset high causes no recapture. All outputs keep their values even when the straps have changed.
- R3: In ST_HELD, a power-up reset pulse with the local reset high does not reopen the latch. All outputs keep their values.
- R4: While the power-up and local resets are both low, the block returns to ST_OPEN with the defaults: `cfg_valid`=0, `bus_mode`=0, `freq_class`=0, `strap_bad`=0 and `pll_early`=0. The next local reset release captures again.
- R5: With `strap_halt`=1 and `strap_tgt_rdy`=1, the mode is conventional (`bus_mode`=0). `freq_class` is 0 (33 MHz) when `strap_hi_speed_en`=0 and 1 (66 MHz) when it is 1.
- R6: The other three halt/target-ready combinations select PCI-X (`bus_mode`=1). halt=1 with tgt_rdy=0 gives class 2 (50–66 MHz). halt=0 with tgt_rdy=1 gives class 3 (66–100 MHz). Both at 0 give class 4 (100–133 MHz). `strap_hi_speed_en` has no effect in this mode.
- R7: If `strap_cyc_start`, `strap_init_rdy` or `strap_sel_ack` is low at capture, `strap_bad`=1 and the result is forced to conventional mode, class 0.
- R8: `pll_early` is 1 when the synchronized PLL reset was already high at the capture clock, and 0 when the PLL reset was still low.
- R9: `cfg_valid` rises at the first capture and stays high until the reopen condition of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-derived clock |
| por_rst_n | input | 1 | Power-up reset, active low |
| loc_rst_n | input | 1 | Local bus reset, active low; its release is the capture point |
| pll_rst_n | input | 1 | PLL reset, active low |
| strap_cyc_start | input | 1 | Cycle-start strap, expected high |
| strap_init_rdy | input | 1 | Initiator-ready strap, expected high |
| strap_sel_ack | input | 1 | Device-select strap, expected high |
| strap_halt | input | 1 | Halt (stop) strap, mode/range select |
| strap_tgt_rdy | input | 1 | Target-ready strap, mode/range select |
| strap_hi_speed_en | input | 1 | 66 MHz enable strap, used in conventional mode only |
| bus_mode | output | 1 | 0 conventional PCI, 1 PCI-X |
| freq_class | output | 3 | 0=33, 1=66, 2=X66, 3=X100, 4=X133 |
| cfg_valid | output | 1 | A capture is held |
| strap_bad | output | 1 | An idle-high strap was low at capture |
| pll_early | output | 1 | PLL reset was released before capture |

## Verification
The bench builds the block with the default `SYNC_STAGES`=2. It derives the capture latency from its own copy of that value. This puts the exact capture clock within reach: the bench checks one edge before capture as well as the capture edge itself. With this setting it covers all six decode patterns, both values of the ignored enable strap in PCI-X mode, and each idle-high strap low alone. It also runs the three reset orderings that must, or must not, reopen the latch.

// File: rtl/bus_strap_pkg.sv
package bus_strap_pkg;

    typedef enum logic {
        MODE_CONV = 1'b0,
        MODE_EXT  = 1'b1
    } bus_mode_e;

    typedef enum logic [2:0] {
        FC_33   = 3'd0,
        FC_66   = 3'd1,
        FC_X66  = 3'd2,
        FC_X100 = 3'd3,
        FC_X133 = 3'd4
    } freq_class_e;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic cyc_start;
        logic init_rdy;
        logic sel_ack;
        logic halt;
        logic tgt_rdy;
        logic hi_speed_en;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    typedef struct packed {
        bus_mode_e   mode;
        freq_class_e fclass;
        logic        bad;
    } strap_cfg_t;

    localparam strap_cfg_t CFG_DEFAULT = '{mode: MODE_CONV, fclass: FC_33, bad: 1'b0};

endpackage

// File: rtl/strap_sync_bank.sv
module strap_sync_bank #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/strap_decode.sv
module strap_decode
    import bus_strap_pkg::*;
(
    input  strap_t     straps,
    output strap_cfg_t cfg
);

    logic idle_ok;

    always_comb begin
        idle_ok = straps.cyc_start & straps.init_rdy & straps.sel_ack;
        cfg     = CFG_DEFAULT;
        if (!idle_ok) begin
            cfg.bad = 1'b1;
        end else begin
            unique case ({straps.halt, straps.tgt_rdy})
                2'b11: begin
                    cfg.mode   = MODE_CONV;
                    cfg.fclass = straps.hi_speed_en ? FC_66 : FC_33;
                end
                2'b10: begin
                    cfg.mode   = MODE_EXT;
                    cfg.fclass = FC_X66;
                end
                2'b01: begin
                    cfg.mode   = MODE_EXT;
                    cfg.fclass = FC_X100;
                end
                2'b00: begin
                    cfg.mode   = MODE_EXT;
                    cfg.fclass = FC_X133;
                end
                default: cfg = CFG_DEFAULT;
            endcase
        end
    end

endmodule

// File: rtl/strap_hold_fsm.sv
module strap_hold_fsm
    import bus_strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_edge,
    input  strap_cfg_t cfg_in,
    input  logic       pll_done,
    output strap_cfg_t cfg_q,
    output logic       valid,
    output logic       pll_early
);

    hold_state_e state_q, state_d;
    logic        take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // transitions and capture strobe
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (cap_edge) begin
                    take    = 1'b1;
                    state_d = ST_HELD;
                end
            end
            ST_HELD: state_d = ST_HELD;
            default: state_d = ST_OPEN;
        endcase
    end

    // held configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= CFG_DEFAULT;
            pll_early <= 1'b0;
        end else if (take) begin
            cfg_q     <= cfg_in;
            pll_early <= pll_done;
        end
    end

    assign valid = (state_q == ST_HELD);

endmodule

// File: rtl/bus_strap_latch.sv
module bus_strap_latch
    import bus_strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_rst_n,
    input  logic       loc_rst_n,
    input  logic       pll_rst_n,
    input  logic       strap_cyc_start,
    input  logic       strap_init_rdy,
    input  logic       strap_sel_ack,
    input  logic       strap_halt,
    input  logic       strap_tgt_rdy,
    input  logic       strap_hi_speed_en,
    output logic       bus_mode,
    output logic [2:0] freq_class,
    output logic       cfg_valid,
    output logic       strap_bad,
    output logic       pll_early
);

    logic       reopen_rel_n;
    logic       hold_rst_n;
    logic       loc_s;
    logic       loc_seen;
    logic       loc_rise;
    logic       pll_s;
    strap_t     straps_raw;
    logic [STRAP_W-1:0] straps_s;
    strap_cfg_t cfg_dec;
    strap_cfg_t cfg_q;

    // reopen only while both resets are low together
    assign reopen_rel_n = por_rst_n | loc_rst_n;

    strap_sync_bank #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_reopen_sync (
        .clk(clk), .rst_n(reopen_rel_n), .d(1'b1), .q(hold_rst_n)
    );

    strap_sync_bank #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_loc_sync (
        .clk(clk), .rst_n(loc_rst_n), .d(1'b1), .q(loc_s)
    );

    strap_sync_bank #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pll_sync (
        .clk(clk), .rst_n(pll_rst_n), .d(1'b1), .q(pll_s)
    );

    assign straps_raw = '{cyc_start: strap_cyc_start, init_rdy: strap_init_rdy,
                          sel_ack: strap_sel_ack, halt: strap_halt,
                          tgt_rdy: strap_tgt_rdy, hi_speed_en: strap_hi_speed_en};

    strap_sync_bank #(.W(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL({STRAP_W{1'b1}})) u_strap_sync (
        .clk(clk), .rst_n(por_rst_n), .d(straps_raw), .q(straps_s)
    );

    // low-to-high detection of the synchronized local reset
    always_ff @(posedge clk or negedge loc_rst_n) begin
        if (!loc_rst_n) loc_seen <= 1'b0;
        else            loc_seen <= loc_s;
    end

    assign loc_rise = loc_s & ~loc_seen;

    strap_decode u_decode (
        .straps(strap_t'(straps_s)),
        .cfg   (cfg_dec)
    );

    strap_hold_fsm u_hold (
        .clk      (clk),
        .rst_n    (hold_rst_n),
        .cap_edge (loc_rise),
        .cfg_in   (cfg_dec),
        .pll_done (pll_s),
        .cfg_q    (cfg_q),
        .valid    (cfg_valid),
        .pll_early(pll_early)
    );

    assign bus_mode   = cfg_q.mode;
    assign freq_class = cfg_q.fclass;
    assign strap_bad  = cfg_q.bad;

endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk (
    input logic       clk,
    input logic       hold_rst_n,
    input logic       loc_rise,
    input logic       cfg_valid,
    input logic       bus_mode,
    input logic [2:0] freq_class,
    input logic       strap_bad,
    input logic       pll_early
);

    // R9
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
        cfg_valid |=> cfg_valid);

    // R2
    held_stable_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
        cfg_valid |=> $stable({bus_mode, freq_class, strap_bad, pll_early}));

    // R1
    capture_on_edge_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
        $rose(cfg_valid) |-> $past(loc_rise));

    // R4
    open_defaults_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
        !cfg_valid |-> (!bus_mode && freq_class == 3'd0 && !strap_bad && !pll_early));

    // R5
    conv_class_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
        (cfg_valid && !bus_mode) |-> (freq_class <= 3'd1));

    // R6
    ext_class_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
        (cfg_valid && bus_mode) |-> (freq_class >= 3'd2 && freq_class <= 3'd4));

    // R7
    bad_default_chk: assert property (@(posedge clk) disable iff (!hold_rst_n)
        strap_bad |-> (!bus_mode && freq_class == 3'd0));

endmodule

bind bus_strap_latch strap_latch_chk u_chk (
    .clk       (clk),
    .hold_rst_n(hold_rst_n),
    .loc_rise  (loc_rise),
    .cfg_valid (cfg_valid),
    .bus_mode  (bus_mode),
    .freq_class(freq_class),
    .strap_bad (strap_bad),
    .pll_early (pll_early)
);

// File: tb/test_bus_strap_latch.sv
module test_bus_strap_latch;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       por_rst_n = 1'b1;
    logic       loc_rst_n = 1'b1;
    logic       pll_rst_n = 1'b1;
    logic       s_cyc = 1'b1, s_irdy = 1'b1, s_sel = 1'b1;
    logic       s_halt = 1'b1, s_tgt = 1'b1, s_hs = 1'b1;
    logic       bus_mode;
    logic [2:0] freq_class;
    logic       cfg_valid;
    logic       strap_bad;
    logic       pll_early;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    bus_strap_latch #(.SYNC_STAGES(SYNC)) i_bus_strap_latch (
        .clk(clk), .por_rst_n(por_rst_n), .loc_rst_n(loc_rst_n), .pll_rst_n(pll_rst_n),
        .strap_cyc_start(s_cyc), .strap_init_rdy(s_irdy), .strap_sel_ack(s_sel),
        .strap_halt(s_halt), .strap_tgt_rdy(s_tgt), .strap_hi_speed_en(s_hs),
        .bus_mode(bus_mode), .freq_class(freq_class), .cfg_valid(cfg_valid),
        .strap_bad(strap_bad), .pll_early(pll_early)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {cyc_start, init_rdy, sel_ack, halt, tgt_rdy, hi_speed_en}
    task automatic set_straps(input logic [5:0] v);
        {s_cyc, s_irdy, s_sel, s_halt, s_tgt, s_hs} = v;
    endtask

    task automatic check_out(input string tag, input int em, input int ec, input int eb, input int ep);
        chk({tag, " cfg_valid"},  cfg_valid,  1);
        chk({tag, " bus_mode"},   bus_mode,   em);
        chk({tag, " freq_class"}, freq_class, ec);
        chk({tag, " strap_bad"},  strap_bad,  eb);
        chk({tag, " pll_early"},  pll_early,  ep);
    endtask

    // full reopen followed by a capture
    task automatic full_capture(input logic [5:0] v, input bit pll_first,
                                input int em, input int ec, input int eb, input int ep,
                                input string tag);
        @(negedge clk);
        por_rst_n = 1'b0; loc_rst_n = 1'b0; pll_rst_n = 1'b0;
        wait_cyc(4);
        chk({tag, " R4 valid cleared"}, cfg_valid, 0);
        chk({tag, " R4 class default"}, freq_class, 0);
        set_straps(v);
        if (pll_first) pll_rst_n = 1'b1;
        por_rst_n = 1'b1;
        wait_cyc(4);
        loc_rst_n = 1'b1;
        wait_cyc(SYNC);
        chk({tag, " R1 not yet captured"}, cfg_valid, 0);
        wait_cyc(1);
        check_out(tag, em, ec, eb, ep);
        pll_rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_reset_state();
        wait_cyc(3);
        chk("R4 reset cfg_valid", cfg_valid, 0);
        chk("R4 reset bus_mode", bus_mode, 0);
        chk("R4 reset freq_class", freq_class, 0);
        chk("R4 reset strap_bad", strap_bad, 0);
        chk("R4 reset pll_early", pll_early, 0);
    endtask

    task automatic t_conv_decode();
        full_capture(6'b111110, 1'b1, 0, 0, 0, 1, "R5 conv 33");
        full_capture(6'b111111, 1'b1, 0, 1, 0, 1, "R5 conv 66");
    endtask

    task automatic t_ext_decode();
        full_capture(6'b111100, 1'b1, 1, 2, 0, 1, "R6 ext 66 en0");
        full_capture(6'b111101, 1'b1, 1, 2, 0, 1, "R6 ext 66 en1");
        full_capture(6'b111010, 1'b1, 1, 3, 0, 1, "R6 ext 100 en0");
        full_capture(6'b111011, 1'b1, 1, 3, 0, 1, "R6 ext 100 en1");
        full_capture(6'b111000, 1'b1, 1, 4, 0, 1, "R6 ext 133 en0");
        full_capture(6'b111001, 1'b1, 1, 4, 0, 1, "R6 ext 133 en1");
    endtask

    task automatic t_bad_straps();
        full_capture(6'b011111, 1'b1, 0, 0, 1, 1, "R7 cyc_start low");
        full_capture(6'b101000, 1'b1, 0, 0, 1, 1, "R7 init_rdy low");
        full_capture(6'b110000, 1'b1, 0, 0, 1, 1, "R7 sel_ack low");
    endtask

    task automatic t_pll_late();
        full_capture(6'b111011, 1'b0, 1, 3, 0, 0, "R8 pll late");
        full_capture(6'b111011, 1'b1, 1, 3, 0, 1, "R8 pll early");
    endtask

    task automatic t_loc_pulse();
        full_capture(6'b111111, 1'b1, 0, 1, 0, 1, "R2 setup");
        set_straps(6'b111000);
        loc_rst_n = 1'b0;
        wait_cyc(3);
        chk("R9 valid during local reset", cfg_valid, 1);
        loc_rst_n = 1'b1;
        wait_cyc(SYNC + 3);
        check_out("R2 no recapture", 0, 1, 0, 1);
    endtask

    task automatic t_por_pulse();
        set_straps(6'b110000);
        por_rst_n = 1'b0;
        wait_cyc(3);
        por_rst_n = 1'b1;
        wait_cyc(SYNC + 3);
        check_out("R3 por alone", 0, 1, 0, 1);
    endtask

    task automatic t_overlap_reopen();
        por_rst_n = 1'b0;
        wait_cyc(2);
        loc_rst_n = 1'b0;
        wait_cyc(3);
        chk("R4 overlap valid cleared", cfg_valid, 0);
        chk("R4 overlap mode default", bus_mode, 0);
        set_straps(6'b111011);
        por_rst_n = 1'b1;
        wait_cyc(3);
        loc_rst_n = 1'b1;
        wait_cyc(SYNC + 1);
        check_out("R4 recapture", 1, 3, 0, 1);
    endtask

    initial begin
        #1;
        por_rst_n = 1'b0;
        loc_rst_n = 1'b0;
        pll_rst_n = 1'b0;
        t_reset_state();
        t_conv_decode();
        t_ext_decode();
        t_bad_straps();
        t_pll_late();
        t_loc_pulse();
        t_por_pulse();
        t_overlap_reopen();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule